// File: doc/BRIEF.md
# Serial Link Bring-up Sequencer

This block takes one end of a full-duplex serial link from reset to the point where user data may flow. It keeps the local receiver disabled until the local transmitter reports lock to its frame-rate strobe. It then has the transmitter send a square-wave training pattern while the receiver searches for frame lock. When the receiver has frame lock, the block disables the frequency detector, marks itself active and switches the transmitter to a ready frame. Data transfer is enabled only after the far end's ready frame has been seen on two consecutive frame strobes.

The block watches both lock inputs on every clock. Losing either one, or changing the word-width or speed option while the link is up, sends the sequence back to training so that both ends resynchronize. The word-width and speed options are registered here and passed on to the datapath.

Top module: `link_bringup_ctrl`

## Requirements
- R1: `rx_enable_o` stays 0 while `tx_lock_i` is 0, and becomes 1 one clock after `tx_lock_i` is seen high.
- R2: Whenever `status_o` is 2'b00, `tx_sel_o` is 2'b00, which selects the training square wave.
- R3: One clock after `rx_flock_i` is seen high in the training state, `status_o` becomes 2'b10.
- R4: `fdet_off_o` goes high in the same clock as status bit 1. `active_o` follows one clock later, and it is never 1 while `fdet_off_o` is 0.
- R5: In the clock in which `active_o` rises, `tx_sel_o` changes to 2'b01, which selects the ready frame.
- R6: The far-end ready indication `far_rdy_i` is taken only on cycles where `frame_stb_i` is 1. It is accepted after two consecutive such strobes with `far_rdy_i`=1. A strobe with `far_rdy_i`=0 restarts the count.
- R7: One clock after acceptance, `status_o` becomes 2'b11 and `tx_sel_o` becomes 2'b10, which selects user data.
- R8: If `rx_flock_i` is 0 while `status_o` is not 2'b00, then one clock later `status_o`=2'b00, `tx_sel_o`=2'b00, `fdet_off_o`=0 and `active_o`=0.
- R9: If `tx_lock_i` is 0 in any state, then one clock later `rx_enable_o`=0, `status_o`=2'b00 and `active_o`=0.
- R10: A change of `word20_i` or `speed_i` while `active_o` is 1 returns `status_o` and `tx_sel_o` to 2'b00 one clock later.
- R11: `word20_o` and `speed_o` equal `word20_i` and `speed_i` registered by one clock.
- R12: A synchronous `rst` returns every output to 0 at the next clock edge, whatever the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_lock_i | input | 1 | Local transmitter locked to its frame strobe |
| rx_flock_i | input | 1 | Local receiver has frame lock |
| frame_stb_i | input | 1 | One-cycle pulse per received frame |
| far_rdy_i | input | 1 | Received frame is a ready frame (valid with strobe) |
| word20_i | input | 1 | Word width option: 0 = 16 bit, 1 = 20 bit |
| speed_i | input | 2 | Speed range option |
| rx_enable_o | output | 1 | Enable for the local receiver |
| status_o | output | 2 | Link status: 00 training, 10 local ready, 11 both ready |
| fdet_off_o | output | 1 | Frequency detector disable |
| active_o | output | 1 | Local receiver in active mode |
| tx_sel_o | output | 2 | Transmit pattern: 00 training, 01 ready frame, 10 data |
| word20_o | output | 1 | Registered word width option |
| speed_o | output | 2 | Registered speed option |

## Verification
The assertions check the encoding rules on every cycle. Status 00 always pairs with the training pattern and status 11 with data. The active flag never stands without the detector disable, and it rises only after that disable is already up. Loss of either lock drops the status within one clock, and acceptance of the far end only ever follows a qualifying strobe. The bench scenarios cover what depends on history: the exact clock of each step in bring-up, the count restarting after a corrupted ready frame, option changes forcing retraining, and a reset in the middle of operation.

// File: rtl/link_bringup_pkg.sv
package link_bringup_pkg;

  typedef enum logic [2:0] {
    LS_IDLE  = 3'd0,
    LS_TRAIN = 3'd1,
    LS_FDOFF = 3'd2,
    LS_READY = 3'd3,
    LS_DATA  = 3'd4
  } lnk_state_e;

  typedef enum logic [1:0] {
    TXS_TRAIN = 2'b00,
    TXS_READY = 2'b01,
    TXS_DATA  = 2'b10
  } tx_sel_e;

  localparam logic [1:0] STAT_WAIT  = 2'b00;
  localparam logic [1:0] STAT_LOCAL = 2'b10;
  localparam logic [1:0] STAT_BOTH  = 2'b11;

endpackage

// File: rtl/lbc_opt_hold.sv
module lbc_opt_hold #(
  parameter int SPEED_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               word20_i,
  input  logic [SPEED_W-1:0] speed_i,
  output logic               word20_q,
  output logic [SPEED_W-1:0] speed_q,
  output logic               opt_chg
);

  always_ff @(posedge clk) begin
    if (rst) begin
      word20_q <= 1'b0;
      speed_q  <= '0;
    end else begin
      word20_q <= word20_i;
      speed_q  <= speed_i;
    end
  end

  always_comb begin
    opt_chg = (word20_i != word20_q) || (speed_i != speed_q);
  end

  // R11
  opt_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (speed_q == $past(speed_i)) && (word20_q == $past(word20_i)));

endmodule

// File: rtl/lbc_remote_qual.sv
module lbc_remote_qual #(
  parameter int QUAL_FRAMES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic stb_i,
  input  logic rdy_i,
  output logic ok_o
);

  localparam int CW = $clog2(QUAL_FRAMES + 1);
  localparam logic [CW-1:0] QMAX = CW'(QUAL_FRAMES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
    end else if (stb_i) begin
      if (!rdy_i) begin
        cnt_q <= '0;
      end else if (cnt_q != QMAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    ok_o = (cnt_q == QMAX);
  end

  // R6
  accept_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ok_o) |-> $past(stb_i && rdy_i));

  // R6
  reject_resets_chk: assert property (@(posedge clk) disable iff (rst)
    (stb_i && !rdy_i) |=> !ok_o);

endmodule

// File: rtl/lbc_seq_fsm.sv
module lbc_seq_fsm
  import link_bringup_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_lock_i,
  input  logic       rx_flock_i,
  input  logic       remote_ok_i,
  input  logic       opt_chg_i,
  output logic       qual_clr_o,
  output logic       rx_enable_o,
  output logic [1:0] status_o,
  output logic       fdet_off_o,
  output logic       active_o,
  output logic [1:0] tx_sel_o
);

  lnk_state_e state_q, state_d;
  logic       link_up;

  always_comb begin
    link_up = (state_q == LS_READY) || (state_q == LS_DATA);
    state_d = state_q;
    if (!tx_lock_i) begin
      state_d = LS_IDLE;
    end else if (state_q != LS_IDLE && !rx_flock_i) begin
      state_d = LS_TRAIN;
    end else if (link_up && opt_chg_i) begin
      state_d = LS_TRAIN;
    end else begin
      case (state_q)
        LS_IDLE:  state_d = LS_TRAIN;
        LS_TRAIN: if (rx_flock_i) state_d = LS_FDOFF;
        LS_FDOFF: state_d = LS_READY;
        LS_READY: if (remote_ok_i) state_d = LS_DATA;
        LS_DATA:  state_d = LS_DATA;
        default:  state_d = LS_IDLE;
      endcase
    end
  end

  always_comb begin
    qual_clr_o = !link_up;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= LS_IDLE;
      rx_enable_o <= 1'b0;
      status_o    <= STAT_WAIT;
      fdet_off_o  <= 1'b0;
      active_o    <= 1'b0;
      tx_sel_o    <= TXS_TRAIN;
    end else begin
      state_q     <= state_d;
      rx_enable_o <= (state_d != LS_IDLE);
      fdet_off_o  <= (state_d == LS_FDOFF) || (state_d == LS_READY) ||
                     (state_d == LS_DATA);
      active_o    <= (state_d == LS_READY) || (state_d == LS_DATA);
      case (state_d)
        LS_FDOFF: begin status_o <= STAT_LOCAL; tx_sel_o <= TXS_TRAIN; end
        LS_READY: begin status_o <= STAT_LOCAL; tx_sel_o <= TXS_READY; end
        LS_DATA:  begin status_o <= STAT_BOTH;  tx_sel_o <= TXS_DATA;  end
        default:  begin status_o <= STAT_WAIT;  tx_sel_o <= TXS_TRAIN; end
      endcase
    end
  end

  // R2
  train_pattern_chk: assert property (@(posedge clk) disable iff (rst)
    (status_o == STAT_WAIT) |-> (tx_sel_o == TXS_TRAIN));

  // R7
  data_pattern_chk: assert property (@(posedge clk) disable iff (rst)
    (status_o == STAT_BOTH) |-> (tx_sel_o == TXS_DATA));

  // R4
  active_needs_fdoff_chk: assert property (@(posedge clk) disable iff (rst)
    active_o |-> fdet_off_o);

  // R4
  fdoff_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(active_o) |-> $past(fdet_off_o));

  // R8
  rx_loss_chk: assert property (@(posedge clk) disable iff (rst)
    (!rx_flock_i && status_o != STAT_WAIT) |=>
      (status_o == STAT_WAIT && !active_o && !fdet_off_o));

  // R9
  tx_loss_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_lock_i |=> (!rx_enable_o && !active_o));

endmodule

// File: rtl/link_bringup_ctrl.sv
module link_bringup_ctrl #(
  parameter int SPEED_W     = 2,
  parameter int QUAL_FRAMES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tx_lock_i,
  input  logic               rx_flock_i,
  input  logic               frame_stb_i,
  input  logic               far_rdy_i,
  input  logic               word20_i,
  input  logic [SPEED_W-1:0] speed_i,
  output logic               rx_enable_o,
  output logic [1:0]         status_o,
  output logic               fdet_off_o,
  output logic               active_o,
  output logic [1:0]         tx_sel_o,
  output logic               word20_o,
  output logic [SPEED_W-1:0] speed_o
);

  logic opt_chg;
  logic remote_ok;
  logic qual_clr;

  lbc_opt_hold #(.SPEED_W(SPEED_W)) u_opt (
    .clk      (clk),
    .rst      (rst),
    .word20_i (word20_i),
    .speed_i  (speed_i),
    .word20_q (word20_o),
    .speed_q  (speed_o),
    .opt_chg  (opt_chg)
  );

  lbc_remote_qual #(.QUAL_FRAMES(QUAL_FRAMES)) u_qual (
    .clk   (clk),
    .rst   (rst),
    .clr_i (qual_clr),
    .stb_i (frame_stb_i),
    .rdy_i (far_rdy_i),
    .ok_o  (remote_ok)
  );

  lbc_seq_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .tx_lock_i   (tx_lock_i),
    .rx_flock_i  (rx_flock_i),
    .remote_ok_i (remote_ok),
    .opt_chg_i   (opt_chg),
    .qual_clr_o  (qual_clr),
    .rx_enable_o (rx_enable_o),
    .status_o    (status_o),
    .fdet_off_o  (fdet_off_o),
    .active_o    (active_o),
    .tx_sel_o    (tx_sel_o)
  );

  // R12
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (status_o == 2'b00 && !rx_enable_o && !active_o && !fdet_off_o));

endmodule

// File: tb/test_link_bringup_ctrl.sv
module test_link_bringup_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_lock_i = 1'b0;
  logic       rx_flock_i = 1'b0;
  logic       frame_stb_i = 1'b0;
  logic       far_rdy_i = 1'b0;
  logic       word20_i = 1'b0;
  logic [1:0] speed_i = 2'b00;
  logic       rx_enable_o;
  logic [1:0] status_o;
  logic       fdet_off_o;
  logic       active_o;
  logic [1:0] tx_sel_o;
  logic       word20_o;
  logic [1:0] speed_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  link_bringup_ctrl i_link_bringup_ctrl (
    .clk         (clk),
    .rst         (rst),
    .tx_lock_i   (tx_lock_i),
    .rx_flock_i  (rx_flock_i),
    .frame_stb_i (frame_stb_i),
    .far_rdy_i   (far_rdy_i),
    .word20_i    (word20_i),
    .speed_i     (speed_i),
    .rx_enable_o (rx_enable_o),
    .status_o    (status_o),
    .fdet_off_o  (fdet_off_o),
    .active_o    (active_o),
    .tx_sel_o    (tx_sel_o),
    .word20_o    (word20_o),
    .speed_o     (speed_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // packs rx_enable, status, fdet_off, active, tx_sel into one value
  function automatic int outs();
    return {rx_enable_o, status_o, fdet_off_o, active_o, tx_sel_o};
  endfunction

  function automatic int pk(bit en, bit [1:0] st, bit fd, bit ac, bit [1:0] sel);
    return {en, st, fd, ac, sel};
  endfunction

  task automatic strobe(input bit rdy);
    frame_stb_i = 1'b1;
    far_rdy_i   = rdy;
    step(1);
    frame_stb_i = 1'b0;
    far_rdy_i   = 1'b0;
    step(1);
  endtask

  task automatic do_reset();
    rst = 1'b1; tx_lock_i = 1'b0; rx_flock_i = 1'b0;
    frame_stb_i = 1'b0; far_rdy_i = 1'b0;
    step(2);
    rst = 1'b0;
  endtask

  task automatic reach_data();
    tx_lock_i = 1'b1; rx_flock_i = 1'b1;
    step(3);
    strobe(1'b1);
    strobe(1'b1);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R12", "outputs after reset", outs(), 0);
    chk("R12", "options after reset", {word20_o, speed_o}, 0);
  endtask

  task automatic t_bringup();
    do_reset();
    step(4);
    chk("R1", "rx disabled without tx lock", outs(), pk(0, 2'b00, 0, 0, 2'b00));
    tx_lock_i = 1'b1;
    step(1);
    chk("R1", "rx enabled after tx lock", outs(), pk(1, 2'b00, 0, 0, 2'b00));
    step(3);
    chk("R2", "training while waiting", outs(), pk(1, 2'b00, 0, 0, 2'b00));
    rx_flock_i = 1'b1;
    step(1);
    chk("R3", "status 10 after frame lock", status_o, 2);
    chk("R4", "fdet off before active", outs(), pk(1, 2'b10, 1, 0, 2'b00));
    step(1);
    chk("R5", "ready frame with active", outs(), pk(1, 2'b10, 1, 1, 2'b01));
    strobe(1'b1);
    chk("R6", "one strobe not accepted", outs(), pk(1, 2'b10, 1, 1, 2'b01));
    frame_stb_i = 1'b1; far_rdy_i = 1'b1;
    step(1);
    frame_stb_i = 1'b0; far_rdy_i = 1'b0;
    chk("R7", "no data yet on qualifying edge", status_o, 2);
    step(1);
    chk("R7", "data enabled", outs(), pk(1, 2'b11, 1, 1, 2'b10));
  endtask

  task automatic t_corrupt_frame();
    do_reset();
    tx_lock_i = 1'b1; rx_flock_i = 1'b1;
    step(3);
    strobe(1'b1);
    strobe(1'b0);
    strobe(1'b1);
    step(2);
    chk("R6", "interrupted run not accepted", status_o, 2);
    // non-strobe cycles with far_rdy_i high are ignored
    far_rdy_i = 1'b1;
    step(3);
    far_rdy_i = 1'b0;
    chk("R6", "ready without strobe ignored", status_o, 2);
    strobe(1'b1);
    chk("R6", "second consecutive strobe accepted", status_o, 3);
  endtask

  task automatic t_rx_loss();
    do_reset();
    reach_data();
    chk("R7", "in data before rx loss", status_o, 3);
    rx_flock_i = 1'b0;
    step(1);
    chk("R8", "rx loss returns to training", outs(), pk(1, 2'b00, 0, 0, 2'b00));
    step(3);
    chk("R8", "stays training without lock", outs(), pk(1, 2'b00, 0, 0, 2'b00));
  endtask

  task automatic t_tx_loss();
    do_reset();
    reach_data();
    tx_lock_i = 1'b0;
    step(1);
    chk("R9", "tx loss disables rx", outs(), pk(0, 2'b00, 0, 0, 2'b00));
  endtask

  task automatic t_opt_change();
    do_reset();
    reach_data();
    speed_i = 2'b10;
    step(1);
    chk("R10", "speed change retrains", {status_o, tx_sel_o}, 0);
    chk("R11", "speed registered", speed_o, 2);
    step(2);
    reach_data();
    word20_i = 1'b1;
    step(1);
    chk("R10", "width change retrains", {status_o, tx_sel_o}, 0);
    chk("R11", "width registered", word20_o, 1);
  endtask

  task automatic t_mid_reset();
    do_reset();
    reach_data();
    rst = 1'b1;
    step(1);
    chk("R12", "reset from data", outs(), 0);
    rst = 1'b0;
  endtask

  initial begin
    t_reset_state();
    t_bringup();
    t_corrupt_frame();
    t_rx_loss();
    t_tx_loss();
    t_opt_change();
    t_mid_reset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule